// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Sequencer

This block decides where a processor core fetches next when it takes a fault, a trap or an interrupt, and when it leaves the handler again. Each cycle it samples the current PC, an event class with its vector offset, the privileged base address and a return strobe. On an entry it redirects the fetch to base plus vector and records a return address. On a return it redirects to the recorded address. Bit 0 of any PC marks privileged firmware mode.

The block also owns the shadow-bank select. While this select is set, a fixed group of integer registers (8 to 14, and 25) is steered to an alternate bank. The block turns the select on when it enters from non-privileged code. It turns the select off on a return whose target leaves privileged mode. Arithmetic traps are not handled: they are reported as unsupported and leave all state as it was. After reset the block starts in privileged mode with the shadow bank on and issues one redirect to the reset vector.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, shadowSel is 1, excAddr is 0 and redirectValid is 0. One cycle after reset is released, a redirect to privBase + RESET_VEC (default 1) is issued, with redirectNpc = redirectPc + 4.
- R2: An accepted entry event issues a redirect one cycle later, with redirectPc = privBase + vecOffset and redirectNpc = redirectPc + 4. The evtClass encodings are 1 fault, 2 privileged call, 3 arithmetic, 4 interrupt, 5 machine check and 6 alignment; 0 and 7 are ignored.
- R3: Machine check (class 5) always vectors to privBase + 0x401, and alignment (class 6) always vectors to privBase + 0x301, whatever vecOffset holds.
- R4: Fault, machine check and alignment save curPc into excAddr. A privileged call (class 2) saves curPc + 4.
- R5: An interrupt (class 4) taken with curPc[0] = 1 leaves excAddr unchanged. Taken with curPc[0] = 0, it saves curPc.
- R6: Any entry with curPc[0] = 0 sets shadowSel. While shadowSel is 1, redirectMask has exactly bits 8 to 14 and bit 25 set; otherwise it is 0.
- R7: A return strobe with curPc[0] = 1 redirects to excAddr, with npc = excAddr + 4. It clears shadowSel only if excAddr[0] is 0. It pulses intrRearm in the same cycle as the redirect.
- R8: A return strobe with curPc[0] = 0 pulses illegalOp. It issues no redirect and changes neither excAddr nor shadowSel.
- R9: A software write (excWrEn) stores excWrData into excAddr with bit 1 forced to 0.
- R10: An arithmetic event (class 3) pulses arithUnsupported. It issues no redirect and changes neither excAddr nor shadowSel.
- R11: A request to set shadowSel while it is already 1, or to clear it while it is already 0, pulses bankFault and leaves shadowSel unchanged.
- R12: An entry event takes priority over a return strobe and over an excAddr write in the same cycle: neither of those takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| curPc | input | AW | PC of the instruction being retired; bit 0 = privileged mode |
| evtValid | input | 1 | An event is presented this cycle |
| evtClass | input | 3 | Event class code |
| vecOffset | input | AW | Vector offset for classes without a fixed vector |
| privBase | input | AW | Privileged-mode base address |
| retStrobe | input | 1 | Return-from-exception instruction executes |
| excWrEn | input | 1 | Software write of the saved exception address |
| excWrData | input | AW | Data for that write |
| redirectValid | output | 1 | Fetch redirect pulse |
| redirectPc | output | AW | New PC |
| redirectNpc | output | AW | New PC + 4 |
| excAddr | output | AW | Saved exception address |
| shadowSel | output | 1 | Shadow bank enabled |
| redirectMask | output | NREG | Per-register shadow steering |
| intrRearm | output | 1 | Re-arm interrupt checking after a return |
| illegalOp | output | 1 | Return executed outside privileged mode |
| arithUnsupported | output | 1 | Arithmetic trap not supported |
| bankFault | output | 1 | Redundant shadow-bank switch request |

## Verification
A wrong saved address does not show at entry time. It appears as a wrong redirectPc on the next return, so the bench always follows an entry with a return and checks the target. A shadow select left in the wrong state appears at once on redirectMask, and also as a bankFault pulse on the next entry or return that tries to switch it. Every registered output settles one clock after its stimulus, so each check samples exactly one cycle after the inputs are driven.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_FAULT = 3'd1,
    EV_CALL  = 3'd2,
    EV_ARITH = 3'd3,
    EV_INTR  = 3'd4,
    EV_MCHK  = 3'd5,
    EV_ALIGN = 3'd6,
    EV_RSVD  = 3'd7
  } evClass_e;

  typedef enum logic [1:0] {
    VS_INPUT = 2'd0,
    VS_MCHK  = 2'd1,
    VS_ALIGN = 2'd2,
    VS_RESET = 2'd3
  } vecSel_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    takeEntry;
    logic    saveExc;
    logic    savePlus4;
    vecSel_e vecSel;
    logic    bankOn;
    logic    bankOff;
    logic    doReturn;
    logic    wrExc;
    logic    flagArith;
    logic    flagIllegal;
  } ctrlStrobes_t;

  localparam int unsigned MCHK_VEC     = 32'h0401;
  localparam int unsigned ALIGN_VEC    = 32'h0301;
  localparam int unsigned SHADOW_LO    = 8;
  localparam int unsigned SHADOW_HI    = 14;
  localparam int unsigned SHADOW_EXTRA = 25;

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         privNow,
  input  logic         evtValid,
  input  logic [2:0]   evtClass,
  input  logic         retStrobe,
  input  logic         excWrEn,
  input  logic         excLsb,
  output ctrlStrobes_t strobes
);

  logic     bootPending;
  evClass_e cls;

  assign cls = evClass_e'(evtClass);

  // One reset-vector redirect after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bootPending <= 1'b1;
    else        bootPending <= 1'b0;
  end

  always_comb begin
    strobes = '0;
    strobes.vecSel = VS_INPUT;
    if (bootPending) begin
      strobes.takeEntry = 1'b1;
      strobes.vecSel    = VS_RESET;
    end else if (evtValid && cls != EV_NONE && cls != EV_RSVD) begin
      unique case (cls)
        EV_FAULT: begin
          strobes.takeEntry = 1'b1;
          strobes.saveExc   = 1'b1;
        end
        EV_CALL: begin
          strobes.takeEntry = 1'b1;
          strobes.saveExc   = 1'b1;
          strobes.savePlus4 = 1'b1;
        end
        EV_INTR: begin
          strobes.takeEntry = 1'b1;
          strobes.saveExc   = !privNow;
        end
        EV_MCHK: begin
          strobes.takeEntry = 1'b1;
          strobes.saveExc   = 1'b1;
          strobes.vecSel    = VS_MCHK;
        end
        EV_ALIGN: begin
          strobes.takeEntry = 1'b1;
          strobes.saveExc   = 1'b1;
          strobes.vecSel    = VS_ALIGN;
        end
        EV_ARITH: strobes.flagArith = 1'b1;
        default: ;
      endcase
      strobes.bankOn = strobes.takeEntry && !privNow;
    end else if (retStrobe) begin
      if (privNow) begin
        strobes.doReturn = 1'b1;
        strobes.bankOff  = !excLsb;
      end else begin
        strobes.flagIllegal = 1'b1;
      end
    end
    // Software write loses against any event that claims the cycle
    strobes.wrExc = excWrEn && !bootPending && !(evtValid && cls != EV_NONE && cls != EV_RSVD);
  end

endmodule

// File: rtl/exc_seq_datapath.sv
module exc_seq_datapath
  import exc_seq_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned NREG        = 32,
  parameter int unsigned RESET_VEC   = 1,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [AW-1:0]    curPc,
  input  logic [AW-1:0]    vecOffset,
  input  logic [AW-1:0]    privBase,
  input  logic [AW-1:0]    excWrData,
  output logic             excLsb,
  output logic             redirectValid,
  output logic [AW-1:0]    redirectPc,
  output logic [AW-1:0]    redirectNpc,
  output logic [AW-1:0]    excAddr,
  output logic             shadowSel,
  output logic [NREG-1:0]  redirectMask,
  output logic             intrRearm,
  output logic             illegalOp,
  output logic             arithUnsupported,
  output logic             bankFault
);

  localparam logic [AW-1:0] STEP      = AW'(INSTR_BYTES);
  localparam logic [AW-1:0] VEC_MCHK  = AW'(MCHK_VEC);
  localparam logic [AW-1:0] VEC_ALIGN = AW'(ALIGN_VEC);
  localparam logic [AW-1:0] VEC_RESET = AW'(RESET_VEC);
  localparam logic [AW-1:0] BIT1_CLR  = ~(AW'(2));

  logic [AW-1:0] vecSelected;
  logic [AW-1:0] targetPc;
  logic [AW-1:0] excNext;
  logic          shadowNext;
  logic          bankErrNext;

  always_comb begin
    unique case (strobes.vecSel)
      VS_MCHK:  vecSelected = VEC_MCHK;
      VS_ALIGN: vecSelected = VEC_ALIGN;
      VS_RESET: vecSelected = VEC_RESET;
      default:  vecSelected = vecOffset;
    endcase
  end

  always_comb begin
    if (strobes.takeEntry) targetPc = privBase + vecSelected;
    else                   targetPc = excAddr;
  end

  always_comb begin
    excNext = excAddr;
    if (strobes.saveExc)    excNext = strobes.savePlus4 ? curPc + STEP : curPc;
    else if (strobes.wrExc) excNext = excWrData & BIT1_CLR;
  end

  always_comb begin
    shadowNext  = shadowSel;
    bankErrNext = 1'b0;
    if (strobes.bankOn) begin
      if (shadowSel) bankErrNext = 1'b1;
      else           shadowNext  = 1'b1;
    end else if (strobes.bankOff) begin
      if (!shadowSel) bankErrNext = 1'b1;
      else            shadowNext  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirectValid    <= 1'b0;
      redirectPc       <= '0;
      redirectNpc      <= '0;
      excAddr          <= '0;
      shadowSel        <= 1'b1;
      intrRearm        <= 1'b0;
      illegalOp        <= 1'b0;
      arithUnsupported <= 1'b0;
      bankFault        <= 1'b0;
    end else begin
      redirectValid    <= strobes.takeEntry || strobes.doReturn;
      if (strobes.takeEntry || strobes.doReturn) begin
        redirectPc  <= targetPc;
        redirectNpc <= targetPc + STEP;
      end
      excAddr          <= excNext;
      shadowSel        <= shadowNext;
      intrRearm        <= strobes.doReturn;
      illegalOp        <= strobes.flagIllegal;
      arithUnsupported <= strobes.flagArith;
      bankFault        <= bankErrNext;
    end
  end

  assign excLsb = excAddr[0];

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    if ((g >= SHADOW_LO && g <= SHADOW_HI) || g == SHADOW_EXTRA) begin : g_on
      assign redirectMask[g] = shadowSel;
    end else begin : g_off
      assign redirectMask[g] = 1'b0;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned NREG        = 32,
  parameter int unsigned RESET_VEC   = 1,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   curPc,
  input  logic            evtValid,
  input  logic [2:0]      evtClass,
  input  logic [AW-1:0]   vecOffset,
  input  logic [AW-1:0]   privBase,
  input  logic            retStrobe,
  input  logic            excWrEn,
  input  logic [AW-1:0]   excWrData,
  output logic            redirectValid,
  output logic [AW-1:0]   redirectPc,
  output logic [AW-1:0]   redirectNpc,
  output logic [AW-1:0]   excAddr,
  output logic            shadowSel,
  output logic [NREG-1:0] redirectMask,
  output logic            intrRearm,
  output logic            illegalOp,
  output logic            arithUnsupported,
  output logic            bankFault
);

  ctrlStrobes_t strobes;
  logic         excLsb;

  exc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .privNow   (curPc[0]),
    .evtValid  (evtValid),
    .evtClass  (evtClass),
    .retStrobe (retStrobe),
    .excWrEn   (excWrEn),
    .excLsb    (excLsb),
    .strobes   (strobes)
  );

  exc_seq_datapath #(
    .AW          (AW),
    .NREG        (NREG),
    .RESET_VEC   (RESET_VEC),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .clk              (clk),
    .rst_n            (rst_n),
    .strobes          (strobes),
    .curPc            (curPc),
    .vecOffset        (vecOffset),
    .privBase         (privBase),
    .excWrData        (excWrData),
    .excLsb           (excLsb),
    .redirectValid    (redirectValid),
    .redirectPc       (redirectPc),
    .redirectNpc      (redirectNpc),
    .excAddr          (excAddr),
    .shadowSel        (shadowSel),
    .redirectMask     (redirectMask),
    .intrRearm        (intrRearm),
    .illegalOp        (illegalOp),
    .arithUnsupported (arithUnsupported),
    .bankFault        (bankFault)
  );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evtValid,
  input logic            excWrEn,
  input logic            redirectValid,
  input logic [AW-1:0]   redirectPc,
  input logic [AW-1:0]   redirectNpc,
  input logic [AW-1:0]   excAddr,
  input logic            shadowSel,
  input logic [NREG-1:0] redirectMask,
  input logic            intrRearm,
  input logic            illegalOp,
  input logic            arithUnsupported,
  input logic            bankFault
);

  assert_npc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |-> redirectNpc == redirectPc + AW'(4));

  assert_mask_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirectMask != '0) |-> ($countones(redirectMask) == 8 && shadowSel));

  assert_rearm_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intrRearm |-> redirectValid);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> (!redirectValid && $stable(excAddr) && $stable(shadowSel)));

  assert_wr_bit1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(excWrEn) && !$past(evtValid)) |-> !excAddr[1]);

  assert_arith_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arithUnsupported |-> (!redirectValid && $stable(excAddr) && $stable(shadowSel)));

  assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bankFault |-> $stable(shadowSel));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  import exc_seq_pkg::*;

  localparam int AW = 32;
  localparam int NREG = 32;
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   curPc;
  logic            evtValid;
  logic [2:0]      evtClass;
  logic [AW-1:0]   vecOffset;
  logic [AW-1:0]   privBase;
  logic            retStrobe;
  logic            excWrEn;
  logic [AW-1:0]   excWrData;
  logic            redirectValid;
  logic [AW-1:0]   redirectPc;
  logic [AW-1:0]   redirectNpc;
  logic [AW-1:0]   excAddr;
  logic            shadowSel;
  logic [NREG-1:0] redirectMask;
  logic            intrRearm;
  logic            illegalOp;
  logic            arithUnsupported;
  logic            bankFault;

  int checks = 0;
  int fails  = 0;
  logic [NREG-1:0] expMask;

  always #10 clk = ~clk;

  exc_entry_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic idle();
    evtValid = 0; evtClass = 3'd0; vecOffset = '0; retStrobe = 0;
    excWrEn = 0; excWrData = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire(input logic [2:0] cls, input logic [AW-1:0] pc, input logic [AW-1:0] vec);
    curPc = pc; evtValid = 1; evtClass = cls; vecOffset = vec;
    step();
    idle();
  endtask

  task automatic doRet(input logic [AW-1:0] pc);
    curPc = pc; retStrobe = 1;
    step();
    idle();
  endtask

  task automatic doWrite(input logic [AW-1:0] d);
    excWrEn = 1; excWrData = d;
    step();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); curPc = '0; privBase = BASE;
    repeat (3) @(negedge clk);
    chkEq("R1 shadow in reset", AW'(shadowSel), 1);
    rst_n = 1;
    chkEq("R1 excAddr after reset", excAddr, 0);
    chkEq("R1 no redirect yet", AW'(redirectValid), 0);
    step();
    chkEq("R1 boot redirect valid", AW'(redirectValid), 1);
    chkEq("R1 boot pc", redirectPc, BASE + 1);
    chkEq("R1 boot npc", redirectNpc, BASE + 5);
  endtask

  task automatic t_first_return();
    doRet(BASE | 1);
    chkEq("R7 return pc", redirectPc, 0);
    chkEq("R7 return npc", redirectNpc, 4);
    chkEq("R7 rearm pulse", AW'(intrRearm), 1);
    chkEq("R7 shadow cleared", AW'(shadowSel), 0);
    chkEq("R6 mask off", AW'(redirectMask), 0);
  endtask

  task automatic t_user_fault();
    fire(EV_FAULT, 32'h2000, 32'h0101);
    chkEq("R2 fault valid", AW'(redirectValid), 1);
    chkEq("R2 fault pc", redirectPc, BASE + 32'h101);
    chkEq("R2 fault npc", redirectNpc, BASE + 32'h105);
    chkEq("R4 fault saves pc", excAddr, 32'h2000);
    chkEq("R6 shadow on", AW'(shadowSel), 1);
    chkEq("R6 mask bits", AW'(redirectMask), AW'(expMask));
    chkEq("R7 no rearm on entry", AW'(intrRearm), 0);
    doRet(BASE + 32'h101);
    chkEq("R7 return to fault pc", redirectPc, 32'h2000);
    chkEq("R7 shadow off after return", AW'(shadowSel), 0);
  endtask

  task automatic t_call_and_intr();
    fire(EV_CALL, 32'h3000, 32'h0181);
    chkEq("R4 call saves pc+4", excAddr, 32'h3004);
    chkEq("R6 call shadow on", AW'(shadowSel), 1);
    fire(EV_INTR, BASE + 32'h185, 32'h0201);
    chkEq("R5 priv intr pc", redirectPc, BASE + 32'h201);
    chkEq("R5 priv intr keeps excAddr", excAddr, 32'h3004);
    chkEq("R11 no bank fault in priv", AW'(bankFault), 0);
  endtask

  task automatic t_fixed_vectors();
    fire(EV_MCHK, BASE + 32'h201, 32'h0777);
    chkEq("R3 mchk pc", redirectPc, BASE + 32'h401);
    chkEq("R4 mchk saves pc", excAddr, BASE + 32'h201);
    doRet(BASE + 32'h401);
    chkEq("R7 return to priv pc", redirectPc, BASE + 32'h201);
    chkEq("R7 shadow kept (bit0 set)", AW'(shadowSel), 1);
    doWrite(32'hFFFF_FFFF);
    chkEq("R9 write clears bit1", excAddr, 32'hFFFF_FFFD);
    fire(EV_ALIGN, 32'h4000, 32'h0055);
    chkEq("R3 align pc", redirectPc, BASE + 32'h301);
    chkEq("R11 bank fault on redundant enable", AW'(bankFault), 1);
    chkEq("R11 shadow stays on", AW'(shadowSel), 1);
    chkEq("R4 align saves pc", excAddr, 32'h4000);
  endtask

  task automatic t_illegal_and_bank();
    doWrite(32'h5000);
    chkEq("R9 plain write", excAddr, 32'h5000);
    doRet(32'h5000);
    chkEq("R8 illegal pulse", AW'(illegalOp), 1);
    chkEq("R8 no redirect", AW'(redirectValid), 0);
    chkEq("R8 excAddr unchanged", excAddr, 32'h5000);
    chkEq("R8 shadow unchanged", AW'(shadowSel), 1);
    doRet(BASE + 32'h301);
    chkEq("R7 return pc 0x5000", redirectPc, 32'h5000);
    chkEq("R7 shadow off", AW'(shadowSel), 0);
    doRet(BASE + 32'h301);
    chkEq("R11 bank fault on redundant disable", AW'(bankFault), 1);
    chkEq("R11 shadow stays off", AW'(shadowSel), 0);
    chkEq("R7 redirect still issued", redirectPc, 32'h5000);
  endtask

  task automatic t_arith();
    fire(EV_ARITH, 32'h7000, 32'h0101);
    chkEq("R10 arith flag", AW'(arithUnsupported), 1);
    chkEq("R10 no redirect", AW'(redirectValid), 0);
    chkEq("R10 excAddr unchanged", excAddr, 32'h5000);
    chkEq("R10 shadow unchanged", AW'(shadowSel), 0);
  endtask

  task automatic t_user_intr();
    fire(EV_INTR, 32'h6000, 32'h0101);
    chkEq("R5 user intr saves pc", excAddr, 32'h6000);
    chkEq("R6 intr shadow on", AW'(shadowSel), 1);
    chkEq("R6 mask reg8", AW'(redirectMask[8]), 1);
    chkEq("R6 mask reg25", AW'(redirectMask[25]), 1);
    chkEq("R6 mask reg15 clear", AW'(redirectMask[15]), 0);
  endtask

  task automatic t_priority();
    curPc = BASE + 32'h101; evtValid = 1; evtClass = EV_FAULT; vecOffset = 32'h0181;
    retStrobe = 1; excWrEn = 1; excWrData = 32'h9000;
    step();
    idle();
    chkEq("R12 entry wins pc", redirectPc, BASE + 32'h181);
    chkEq("R12 save beats write", excAddr, BASE + 32'h101);
    chkEq("R12 return ignored", AW'(intrRearm), 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    expMask = '0;
    for (int i = 8; i <= 14; i++) expMask[i] = 1'b1;
    expMask[25] = 1'b1;
    t_reset();
    t_first_return();
    t_user_fault();
    t_call_and_intr();
    t_fixed_vectors();
    t_illegal_and_bank();
    t_arith();
    t_user_intr();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule